// File: doc/BRIEF.md
# Cache Flush Sequencer

This block answers an active-low flush request for a processor's caches. It walks the data-cache tag/state array one line index at a time. Each modified line is written back through a valid/ready request port. It then pulses a single invalidate strobe that clears the data and instruction caches. Last, it issues an acknowledge special cycle on a second valid/ready port.

When two processors share a bus, each gets one instance. The secondary instance sweeps first and reports completion on a done strobe instead of an acknowledge. The primary instance waits for that strobe, sweeps, and then sends the acknowledge. A request that is held low while reset is released does not start a flush. It instead latches a three-state test mode that lasts until the next reset.

Back-pressure rules: once `wb_valid` is raised it stays high, and `wb_line` stays stable, until a cycle in which `wb_ready` is high. Only one write-back is outstanding at any time. `ack_valid` likewise stays high until `ack_ready` is seen. The block never drops a request while waiting for ready.

Top module: `flush_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `busy`, `wb_valid`, `inv_all`, `ack_valid`, `sweep_done` and `proto_err` are all 0.
- R2: A high-to-low transition on `flush_n` while the block is idle and not in test mode starts a flush. `busy` is high in the cycle after the clock edge that sees the low level.
- R3: Every line whose `tag_dirty` bit is 1 is written back exactly once, with `wb_line` equal to its index, in ascending index order. Clean lines are never presented on `wb_valid`.
- R4: When `wb_valid` is high and `wb_ready` is low, `wb_valid` stays high and `wb_line` is unchanged in the next cycle.
- R5: After the last line has been handled, `inv_all` is high for exactly one cycle. This comes after every write-back and before the acknowledge or done strobe.
- R6: Outside the secondary configuration, `ack_valid` rises after the invalidate and stays high until `ack_ready`. `busy` falls in the cycle after that handshake.
- R7: If `flush_n` is low at the last clock edge with `rst` high, `test_mode` is 1 after reset. In that state, falling edges on `flush_n` never raise `busy`. A reset with `flush_n` high clears `test_mode`.
- R8: In the primary configuration (`dual_en`=1, `is_primary`=1), no write-back and no invalidate occur until `peer_done` has been seen high.
- R9: In the secondary configuration (`dual_en`=1, `is_primary`=0), `ack_valid` never rises. Instead `sweep_done` pulses for one cycle after the invalidate, and `busy` falls in the following cycle.
- R10: If `dual_en` is 1 and `flush_n` is still low at the clock edge that completes the acknowledge handshake, `proto_err` is high for the next cycle. With `flush_n` high, or with `dual_en` 0, it stays 0.
- R11: Falling edges of `flush_n` during a flush are ignored: one flush produces one acknowledge, and `busy` stays low afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flush_n | input | 1 | Flush request, active low |
| dual_en | input | 1 | Two-processor ordering enabled |
| is_primary | input | 1 | 1 = primary instance, 0 = secondary (with dual_en) |
| peer_done | input | 1 | Secondary's completion strobe, seen by the primary |
| tag_idx | output | $clog2(LINES) | Line index being examined in the tag array |
| tag_dirty | input | 1 | Modified bit of line `tag_idx` |
| wb_valid | output | 1 | Write-back request valid |
| wb_ready | input | 1 | Write-back request accepted |
| wb_line | output | $clog2(LINES) | Index of the line to write back |
| inv_all | output | 1 | One-cycle invalidate of data and instruction caches |
| ack_valid | output | 1 | Acknowledge special cycle request |
| ack_ready | input | 1 | Ready strobe ending the acknowledge cycle |
| sweep_done | output | 1 | Secondary's one-cycle completion strobe |
| busy | output | 1 | Flush in progress |
| test_mode | output | 1 | Three-state test mode latched at reset |
| proto_err | output | 1 | Request still asserted at the acknowledge ready strobe (dual mode) |

## Verification
The hardest situation to reach is a second request edge that lands in the middle of a sweep. It should be ignored, but if it were not, it would look like a second flush hidden behind the first. The stimulus pulses `flush_n` low again two cycles into a sweep with a stalled write-back port. It then watches for a single acknowledge and for `busy` to stay low afterwards. The three-state latch needs reset to be released while the request is held low, so the bench runs a dedicated reset for it. The primary's wait is covered by holding `peer_done` off for several cycles while a dirty line is pending.

// File: rtl/flush_pkg.sv
package flush_pkg;
  typedef enum logic [2:0] {
    FS_IDLE  = 3'd0,
    FS_PEER  = 3'd1,
    FS_SCAN  = 3'd2,
    FS_WB    = 3'd3,
    FS_INVAL = 3'd4,
    FS_ACK   = 3'd5,
    FS_SIG   = 3'd6
  } fstate_t;
endpackage

// File: rtl/flush_req_capture.sv
module flush_req_capture (
  input  logic clk,
  input  logic rst,
  input  logic flush_n,
  output logic flush_fall,
  output logic test_mode
);
  logic prev_q;
  logic tm_q;

  // the value sampled at the last edge with rst high is kept
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= flush_n;
      tm_q   <= !flush_n;
    end else begin
      prev_q <= flush_n;
    end
  end

  assign flush_fall = prev_q && !flush_n;
  assign test_mode  = tm_q;

  // R7
  test_hold_chk: assert property (@(posedge clk) disable iff (rst)
    test_mode |=> test_mode);
endmodule

// File: rtl/flush_line_walker.sv
module flush_line_walker #(
  parameter int LINES = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clear,
  input  logic                       step,
  output logic [$clog2(LINES)-1:0]   idx,
  output logic                       last
);
  localparam int IDX_W = $clog2(LINES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINES - 1);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst || clear) idx_q <= '0;
    else if (step)    idx_q <= idx_q + 1'b1;
  end

  assign idx  = idx_q;
  assign last = (idx_q == LAST_IDX);

  // R3
  walk_up_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !clear) |=> (idx_q != '0));
endmodule

// File: rtl/flush_ctrl_fsm.sv
module flush_ctrl_fsm
  import flush_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic flush_n,
  input  logic flush_fall,
  input  logic test_mode,
  input  logic dual_en,
  input  logic is_primary,
  input  logic peer_done,
  input  logic tag_dirty,
  input  logic last,
  input  logic wb_ready,
  input  logic ack_ready,
  output logic clear,
  output logic step,
  output logic wb_valid,
  output logic inv_all,
  output logic ack_valid,
  output logic sweep_done,
  output logic busy,
  output logic proto_err
);
  fstate_t st_q, st_d;
  logic    perr_q;
  logic    secondary;

  assign secondary = dual_en && !is_primary;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      FS_IDLE:  if (flush_fall && !test_mode)
                  st_d = (dual_en && is_primary) ? FS_PEER : FS_SCAN;
      FS_PEER:  if (peer_done) st_d = FS_SCAN;
      FS_SCAN:  begin
                  if (tag_dirty) st_d = FS_WB;
                  else if (last) st_d = FS_INVAL;
                end
      FS_WB:    if (wb_ready) st_d = last ? FS_INVAL : FS_SCAN;
      FS_INVAL: st_d = secondary ? FS_SIG : FS_ACK;
      FS_ACK:   if (ack_ready) st_d = FS_IDLE;
      FS_SIG:   st_d = FS_IDLE;
      default:  st_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= FS_IDLE;
      perr_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      perr_q <= (st_q == FS_ACK) && ack_ready && dual_en && !flush_n;
    end
  end

  assign clear      = (st_q == FS_IDLE) || (st_q == FS_PEER);
  assign step       = ((st_q == FS_SCAN) && !tag_dirty && !last) ||
                      ((st_q == FS_WB) && wb_ready && !last);
  assign wb_valid   = (st_q == FS_WB);
  assign inv_all    = (st_q == FS_INVAL);
  assign ack_valid  = (st_q == FS_ACK);
  assign sweep_done = (st_q == FS_SIG);
  assign busy       = (st_q != FS_IDLE);
  assign proto_err  = perr_q;

  // R4
  wb_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && !wb_ready) |=> wb_valid);
  // R5
  inv_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    inv_all |=> !inv_all);
  // R6
  ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && !ack_ready) |=> ack_valid);
  // R6
  ack_end_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && ack_ready) |=> !busy);
  // R9
  sec_no_ack_chk: assert property (@(posedge clk) disable iff (rst)
    secondary |-> !ack_valid);
  // R10
  perr_dual_chk: assert property (@(posedge clk) disable iff (rst)
    proto_err |-> $past(dual_en));
  // R7
  test_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    test_mode |-> !busy);
endmodule

// File: rtl/flush_seq.sv
module flush_seq #(
  parameter int LINES = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     flush_n,
  input  logic                     dual_en,
  input  logic                     is_primary,
  input  logic                     peer_done,
  output logic [$clog2(LINES)-1:0] tag_idx,
  input  logic                     tag_dirty,
  output logic                     wb_valid,
  input  logic                     wb_ready,
  output logic [$clog2(LINES)-1:0] wb_line,
  output logic                     inv_all,
  output logic                     ack_valid,
  input  logic                     ack_ready,
  output logic                     sweep_done,
  output logic                     busy,
  output logic                     test_mode,
  output logic                     proto_err
);
  localparam int IDX_W = $clog2(LINES);

  logic             flush_fall;
  logic             clear;
  logic             step;
  logic             last;
  logic [IDX_W-1:0] idx;

  flush_req_capture u_cap (
    .clk        (clk),
    .rst        (rst),
    .flush_n    (flush_n),
    .flush_fall (flush_fall),
    .test_mode  (test_mode)
  );

  flush_line_walker #(.LINES(LINES)) u_walk (
    .clk   (clk),
    .rst   (rst),
    .clear (clear),
    .step  (step),
    .idx   (idx),
    .last  (last)
  );

  flush_ctrl_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .flush_n    (flush_n),
    .flush_fall (flush_fall),
    .test_mode  (test_mode),
    .dual_en    (dual_en),
    .is_primary (is_primary),
    .peer_done  (peer_done),
    .tag_dirty  (tag_dirty),
    .last       (last),
    .wb_ready   (wb_ready),
    .ack_ready  (ack_ready),
    .clear      (clear),
    .step       (step),
    .wb_valid   (wb_valid),
    .inv_all    (inv_all),
    .ack_valid  (ack_valid),
    .sweep_done (sweep_done),
    .busy       (busy),
    .proto_err  (proto_err)
  );

  assign tag_idx = idx;
  assign wb_line = idx;

  // R4
  wb_line_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && !wb_ready) |=> $stable(wb_line));
endmodule

// File: tb/flush_seq_tb.sv
module flush_seq_tb;
  localparam int LINES = 8;
  localparam int NV = 7;
  // {dirty mask, ready delay}
  localparam logic [11:0] VECS [NV] = '{
    12'h000, 12'hFF2, 12'h812, 12'h013, 12'h5A1, 12'h800, 12'h010
  };

  logic clk = 1'b0;
  logic rst, flush_n, dual_en, is_primary, peer_done;
  logic [2:0] tag_idx, wb_line;
  logic tag_dirty, wb_valid, wb_ready, inv_all, ack_valid, ack_ready;
  logic sweep_done, busy, test_mode, proto_err;
  logic [7:0] dmask;

  int n_tests = 0;
  int n_fail  = 0;

  // results of serve
  logic [7:0] seen, seen_at_inv;
  bit  order_bad, done;
  int  inv_cnt, sw_cnt, ack_cnt, early_wb, inv_before_ack;
  logic r_busy, r_perr;

  always #5 clk = ~clk;
  assign tag_dirty = dmask[tag_idx];

  flush_seq #(.LINES(LINES)) u_dut (
    .clk(clk), .rst(rst), .flush_n(flush_n), .dual_en(dual_en),
    .is_primary(is_primary), .peer_done(peer_done), .tag_idx(tag_idx),
    .tag_dirty(tag_dirty), .wb_valid(wb_valid), .wb_ready(wb_ready),
    .wb_line(wb_line), .inv_all(inv_all), .ack_valid(ack_valid),
    .ack_ready(ack_ready), .sweep_done(sweep_done), .busy(busy),
    .test_mode(test_mode), .proto_err(proto_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic fl);
    @(negedge clk);
    rst = 1'b1; flush_n = fl; wb_ready = 0; ack_ready = 0; peer_done = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic start_flush(input bit release_it);
    flush_n = 1'b1;
    @(negedge clk);
    flush_n = 1'b0;
    @(negedge clk);
    chk(busy == 1'b1, "R2 busy after request", busy, 1);
    if (release_it) flush_n = 1'b1;
  endtask

  task automatic serve(input int dly, input bit repulse, input int peer_at);
    int wcnt, acnt, last_line;
    bit ack_pend, sec_pend;
    wcnt = 0; acnt = 0; last_line = -1; ack_pend = 0; sec_pend = 0;
    seen = '0; seen_at_inv = '0; order_bad = 0; done = 0;
    inv_cnt = 0; sw_cnt = 0; ack_cnt = 0; early_wb = 0; inv_before_ack = -1;
    r_busy = 1'b1; r_perr = 1'b0;
    for (int it = 1; it < 400; it++) begin
      @(negedge clk);
      peer_done = (it == peer_at);
      if (repulse && it == 2) flush_n = 1'b0;
      if (repulse && it == 3) flush_n = 1'b1;
      if (ack_pend) begin
        ack_ready = 0; r_busy = busy; r_perr = proto_err; done = 1; break;
      end
      if (sec_pend) begin
        r_busy = busy; done = 1; break;
      end
      wb_ready = 0;
      if (wb_valid || inv_all) if (it <= peer_at) early_wb++;
      if (wb_valid) begin
        if (wcnt < dly) wcnt++;
        else begin
          wb_ready = 1; wcnt = 0;
          if (int'(wb_line) <= last_line) order_bad = 1;
          last_line = int'(wb_line);
          seen[wb_line] = 1'b1;
        end
      end
      if (inv_all) begin
        inv_cnt++; seen_at_inv = seen; dmask = '0;
      end
      if (ack_valid) begin
        if (acnt < dly) acnt++;
        else begin
          ack_ready = 1; ack_pend = 1; ack_cnt++; inv_before_ack = inv_cnt;
        end
      end
      if (sweep_done) begin
        sw_cnt++; sec_pend = 1;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    dmask = '0; dual_en = 0; is_primary = 0;
    rst = 1; flush_n = 1; wb_ready = 0; ack_ready = 0; peer_done = 0;
    @(negedge clk);
    chk(busy == 0 && wb_valid == 0 && ack_valid == 0, "R1 outputs in reset", busy, 0);
    do_reset(1'b1);
    chk(busy == 0 && inv_all == 0 && sweep_done == 0 && proto_err == 0,
        "R1 outputs after reset", busy, 0);
    chk(test_mode == 0, "R7 no test mode", test_mode, 0);

    // vector table, single-processor mode
    for (int v = 0; v < NV; v++) begin
      logic [7:0] m;
      int d;
      m = VECS[v][11:4];
      d = int'(VECS[v][3:0]);
      dmask = m;
      start_flush(1'b1);
      serve(d, v == 1, 0);
      chk(done, "R6 acknowledge completed", done, 1);
      chk(seen == m, "R3 written lines", seen, m);
      chk(!order_bad, "R3 ascending order", order_bad, 0);
      chk(inv_cnt == 1, "R5 one invalidate", inv_cnt, 1);
      chk(seen_at_inv == m, "R5 write-backs before invalidate", seen_at_inv, m);
      chk(inv_before_ack == 1, "R6 invalidate before ack", inv_before_ack, 1);
      chk(r_busy == 0, "R6 busy falls after ack", r_busy, 0);
      chk(r_perr == 0, "R10 no error in single mode", r_perr, 0);
      if (v == 1) begin
        repeat (4) @(negedge clk);
        chk(ack_cnt == 1 && busy == 0, "R11 mid-flush edge ignored", busy, 0);
      end
    end

    // single mode with request held low through the ack: no error
    dmask = 8'h02;
    start_flush(1'b0);
    serve(0, 0, 0);
    chk(r_perr == 0, "R10 held low, single mode", r_perr, 0);
    flush_n = 1'b1;

    // primary waits for the secondary
    dual_en = 1; is_primary = 1; dmask = 8'h41;
    start_flush(1'b1);
    serve(1, 0, 8);
    chk(early_wb == 0, "R8 no work before peer", early_wb, 0);
    chk(seen == 8'h41, "R8 lines after peer", seen, 8'h41);
    chk(ack_cnt == 1 && r_perr == 0, "R10 released early, no error", r_perr, 0);

    // primary with request still low at ack ready
    dmask = 8'h00;
    start_flush(1'b0);
    serve(0, 0, 3);
    chk(r_perr == 1, "R10 error flagged", r_perr, 1);
    flush_n = 1'b1;
    @(negedge clk);
    chk(proto_err == 0, "R10 error is one cycle", proto_err, 0);

    // secondary
    is_primary = 0; dmask = 8'h24;
    start_flush(1'b1);
    serve(0, 0, 0);
    chk(sw_cnt == 1, "R9 one done strobe", sw_cnt, 1);
    chk(ack_cnt == 0, "R9 no acknowledge", ack_cnt, 0);
    chk(r_busy == 0, "R9 busy falls after done", r_busy, 0);
    chk(seen == 8'h24 && inv_cnt == 1, "R9 sweep complete", seen, 8'h24);
    dual_en = 0;

    // test mode latched at reset
    do_reset(1'b0);
    chk(test_mode == 1, "R7 test mode latched", test_mode, 1);
    flush_n = 1'b1;
    @(negedge clk);
    flush_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 0, "R7 flush ignored in test mode", busy, 0);
    do_reset(1'b1);
    chk(test_mode == 0, "R7 test mode cleared", test_mode, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule